// File: doc/BRIEF.md
# Interval timer channel

This block is one 16-bit down-counting timer channel. Software reaches it through an 8-bit port with three operations: command write, data write and data read. A command byte does one of two things. It can set how the 16-bit count moves over the 8-bit data port and pick the output waveform. Or it can freeze a snapshot of the running count so that software can read it. A qualified tick (`tick` with `gate` high) moves the counter. The count drives `tmr_out` as one of three waveforms:

- a level that rises at terminal count and stays up;
- a periodic one-tick low pulse;
- a square wave.

An interrupt controller downstream would take its request from the rising edge of `tmr_out`. A loaded value of zero stands for the full 65536-tick range. The design assumes `CW == 2*BW`.

Top module: `interval_timer_chan`

## Requirements
- R1: Command decoding uses these fields:
  - Bits 5:4 select the access form: 00 latch, 01 low byte only, 10 high byte only, 11 low byte then high byte.
  - Bits 3:1 are the mode code. Codes 010 and 110 select the rate mode. Codes 011 and 111 select the square mode. All other codes select the terminal-count mode.
  - Bit 0 and bits 7:6 have no effect.
- R2: Any non-latch command sets `tmr_out` to its mode's starting level: low for the terminal-count mode, high for the rate and square modes. It also halts counting and clears both byte toggles and any held snapshot. The count then stays frozen until a new count has been loaded and ticked in.
- R3: Loading works per access form:
  - With low-only access, one data write loads the count with the high byte zero.
  - With high-only access, one data write loads the count with the low byte zero.
  - With low-then-high access, two writes are needed, low byte first, and the load completes on the second.
- R4: The counter picks up a completed load on the first qualified tick after it. A tick taken while `gate` is low changes nothing.
- R5: Terminal-count mode works as follows:
  - A completed load drives `tmr_out` low.
  - `tmr_out` rises on the N+1-th qualified tick after the load (N being the loaded count).
  - `tmr_out` then stays high until the next load or command.
- R6: Terminal-count mode, reload while counting: a new count written while counting restarts the sequence from the new value and forces `tmr_out` low again.
- R7: Rate mode has a period of N qualified ticks, and `tmr_out` is low for exactly one of them. A count of 1 acts as 2.
- R8: Square mode keeps `tmr_out` high for ceil(N/2) qualified ticks and low for floor(N/2) qualified ticks. The low phase is never shorter than one tick.
- R9: A loaded count of 0 behaves as 65536.
- R10: A latch command holds the count as it was at the command. The held value is read back in the programmed byte order (low byte first in two-byte access). It is released once fully read. A latch command issued while a snapshot is still held is ignored.
- R11: After reset:
  - The mode is terminal-count and the access form is low-then-high.
  - `tmr_out` is low and the count is 0.
  - Reads without a snapshot return the live count.
- R12: In rate and square modes, a count written while the channel is running is taken only at the next period reload.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | Count strobe, one pulse per timer tick |
| gate | input | 1 | Counting enable |
| cmd_we | input | 1 | Command write strobe (`wdata` is the command byte) |
| data_we | input | 1 | Data write strobe; ignored in a cycle with `cmd_we` |
| data_re | input | 1 | Data read strobe; advances the read byte order |
| wdata | input | BW | Write byte |
| rdata | output | BW | Read byte for the current byte position |
| tmr_out | output | 1 | Timer output |

## Verification
Each waveform mode is driven with:
- directed counts at the edges (1, 2, odd and even values, 0 as the full range);
- a run of random counts under random mode codes, including the alias codes.

Measured rise delays, phase widths and periods separate correct phase rounding from off-by-one reload errors. Loading through all three access forms shows whether byte placement and byte order are right. Reloads are issued both mid-count and right at a period boundary. These tell an immediate restart apart from a deferred one. Latch and read sequences are placed at known tick offsets, so the exact frozen value is predictable. That also shows whether a repeated latch was ignored.

// File: rtl/itc_pkg.sv
package itc_pkg;

  typedef enum logic [1:0] {
    MD_TERM   = 2'd0,
    MD_RATE   = 2'd1,
    MD_SQUARE = 2'd2
  } mode_e;

  typedef enum logic [1:0] {
    AC_LATCH = 2'b00,
    AC_LO    = 2'b01,
    AC_HI    = 2'b10,
    AC_BOTH  = 2'b11
  } acc_e;

endpackage

// File: rtl/itc_cmd_dec.sv
module itc_cmd_dec import itc_pkg::*; #(
  parameter int BW = 8
) (
  input  logic [BW-1:0] cmd_byte,
  output logic          is_latch,
  output mode_e         mode,
  output acc_e          acc
);
  localparam int MODE_LSB = 1;
  localparam int ACC_LSB  = 4;

  logic [2:0] code;
  logic       unused_bits;

  assign code     = cmd_byte[MODE_LSB +: 3];
  assign acc      = acc_e'(cmd_byte[ACC_LSB +: 2]);
  assign is_latch = (acc == AC_LATCH);

  // upper mode-code bit only creates aliases
  always_comb begin
    unique case (code[1:0])
      2'b10:   mode = MD_RATE;
      2'b11:   mode = MD_SQUARE;
      default: mode = MD_TERM;
    endcase
  end

  assign unused_bits = ^{cmd_byte[BW-1:ACC_LSB+2], cmd_byte[0], code[2]};
endmodule

// File: rtl/itc_wr_seq.sv
module itc_wr_seq import itc_pkg::*; #(
  parameter int CW = 16,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prog,
  input  logic          wr,
  input  acc_e          acc,
  input  logic [BW-1:0] wdata,
  output logic          load_stb,
  output logic [CW:0]   load_val
);
  logic          tog_q, tog_d;
  logic [BW-1:0] lo_q, lo_d;
  logic [CW-1:0] word;

  always_comb begin
    tog_d    = tog_q;
    lo_d     = lo_q;
    load_stb = 1'b0;
    unique case (acc)
      AC_LO:   word = {{(CW-BW){1'b0}}, wdata};
      AC_HI:   word = {wdata, {(CW-BW){1'b0}}};
      default: word = {wdata, lo_q};
    endcase
    if (prog) begin
      tog_d = 1'b0;
    end else if (wr) begin
      if (acc == AC_BOTH) begin
        if (!tog_q) begin
          lo_d  = wdata;
          tog_d = 1'b1;
        end else begin
          tog_d    = 1'b0;
          load_stb = 1'b1;
        end
      end else begin
        load_stb = 1'b1;
      end
    end
  end

  // zero stands for the full range
  assign load_val = (word == '0) ? {1'b1, {CW{1'b0}}} : {1'b0, word};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_q <= 1'b0;
      lo_q  <= '0;
    end else if (prog || wr) begin
      tog_q <= tog_d;
      lo_q  <= lo_d;
    end
  end
endmodule

// File: rtl/itc_rd_seq.sv
module itc_rd_seq import itc_pkg::*; #(
  parameter int CW = 16,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prog,
  input  logic          latch,
  input  logic          rd,
  input  acc_e          acc,
  input  logic [CW-1:0] cnt_live,
  output logic [BW-1:0] rdata,
  output logic          latched
);
  logic          lat_q, lat_d;
  logic          tog_q, tog_d;
  logic [CW-1:0] val_q, val_d;
  logic [CW-1:0] src;
  logic          hi_sel;

  assign src     = lat_q ? val_q : cnt_live;
  assign latched = lat_q;

  always_comb begin
    hi_sel = (acc == AC_HI) || ((acc == AC_BOTH) && tog_q);
    rdata  = hi_sel ? src[CW-1 -: BW] : src[BW-1:0];
    lat_d  = lat_q;
    tog_d  = tog_q;
    val_d  = val_q;
    if (prog) begin
      lat_d = 1'b0;
      tog_d = 1'b0;
    end else if (latch) begin
      if (!lat_q) begin
        lat_d = 1'b1;
        val_d = cnt_live;
        tog_d = 1'b0;
      end
    end else if (rd) begin
      if (acc == AC_BOTH) begin
        tog_d = ~tog_q;
        if (tog_q) lat_d = 1'b0;
      end else begin
        lat_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= 1'b0;
      tog_q <= 1'b0;
      val_q <= '0;
    end else if (prog || latch || rd) begin
      lat_q <= lat_d;
      tog_q <= tog_d;
      val_q <= val_d;
    end
  end
endmodule

// File: rtl/itc_core.sv
module itc_core import itc_pkg::*; #(
  parameter int CW = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        prog,
  input  mode_e       prog_mode,
  input  mode_e       mode,
  input  logic        load_stb,
  input  logic [CW:0] load_val,
  input  logic        en_tick,
  output logic [CW:0] cnt,
  output logic        run,
  output logic        out
);
  localparam int          CNTW = CW + 1;
  localparam logic [CW:0] ONE  = CNTW'(1);
  localparam logic [CW:0] TWO  = CNTW'(2);

  logic [CW:0] cnt_q, cnt_d, rel_q, rel_d;
  logic        run_q, run_d, pend_q, pend_d, out_q, out_d;

  function automatic logic [CW:0] at_least2(input logic [CW:0] v);
    return (v < TWO) ? TWO : v;
  endfunction

  function automatic logic [CW:0] up_even(input logic [CW:0] v);
    return v + {{CW{1'b0}}, v[0]};
  endfunction

  function automatic logic [CW:0] dn_even(input logic [CW:0] v);
    return at_least2({v[CW:1], 1'b0});
  endfunction

  always_comb begin
    cnt_d  = cnt_q;
    rel_d  = rel_q;
    run_d  = run_q;
    pend_d = pend_q;
    out_d  = out_q;
    if (prog) begin
      run_d  = 1'b0;
      pend_d = 1'b0;
      out_d  = (prog_mode != MD_TERM);
    end else begin
      if (en_tick) begin
        if (pend_q) begin
          run_d  = 1'b1;
          pend_d = 1'b0;
          unique case (mode)
            MD_RATE:   cnt_d = at_least2(rel_q);
            MD_SQUARE: cnt_d = up_even(rel_q);
            default:   cnt_d = rel_q;
          endcase
        end else if (run_q) begin
          unique case (mode)
            MD_RATE: begin
              if (cnt_q <= ONE) begin
                cnt_d = at_least2(rel_q);
                out_d = 1'b1;
              end else if (cnt_q == TWO) begin
                cnt_d = ONE;
                out_d = 1'b0;
              end else begin
                cnt_d = cnt_q - ONE;
              end
            end
            MD_SQUARE: begin
              if (cnt_q <= TWO) begin
                out_d = ~out_q;
                cnt_d = out_q ? dn_even(rel_q) : up_even(rel_q);
              end else begin
                cnt_d = cnt_q - TWO;
              end
            end
            default: begin
              cnt_d = (cnt_q == '0) ? {1'b0, {CW{1'b1}}} : cnt_q - ONE;
              if (cnt_q == ONE) out_d = 1'b1;
            end
          endcase
        end
      end
      if (load_stb) begin
        rel_d = load_val;
        if ((mode == MD_TERM) || !run_q) pend_d = 1'b1;
        if (mode == MD_TERM) out_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      rel_q  <= '0;
      run_q  <= 1'b0;
      pend_q <= 1'b0;
      out_q  <= 1'b0;
    end else if (prog || load_stb || en_tick) begin
      cnt_q  <= cnt_d;
      rel_q  <= rel_d;
      run_q  <= run_d;
      pend_q <= pend_d;
      out_q  <= out_d;
    end
  end

  assign cnt = cnt_q;
  assign run = run_q;
  assign out = out_q;
endmodule

// File: rtl/interval_timer_chan.sv
module interval_timer_chan import itc_pkg::*; #(
  parameter int CW = 16,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          gate,
  input  logic          cmd_we,
  input  logic          data_we,
  input  logic          data_re,
  input  logic [BW-1:0] wdata,
  output logic [BW-1:0] rdata,
  output logic          tmr_out
);
  logic [1:0]  rsync_q;
  logic        rst_n_int;
  logic        dec_latch;
  mode_e       dec_mode;
  acc_e        dec_acc;
  logic        prog_stb, latch_stb, wr_stb, en_tick;
  mode_e       mode_q, mode_d;
  acc_e        acc_q, acc_d;
  logic        load_stb;
  logic [CW:0] load_val;
  logic [CW:0] cnt_q;
  logic        run_q;
  logic        latched;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n_int = rsync_q[1];

  itc_cmd_dec #(.BW(BW)) u_dec (
    .cmd_byte (wdata),
    .is_latch (dec_latch),
    .mode     (dec_mode),
    .acc      (dec_acc)
  );

  assign prog_stb  = cmd_we & ~dec_latch;
  assign latch_stb = cmd_we &  dec_latch;
  assign wr_stb    = data_we & ~cmd_we;
  assign en_tick   = tick & gate;

  always_comb begin
    mode_d = mode_q;
    acc_d  = acc_q;
    if (prog_stb) begin
      mode_d = dec_mode;
      acc_d  = dec_acc;
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      mode_q <= MD_TERM;
      acc_q  <= AC_BOTH;
    end else if (prog_stb) begin
      mode_q <= mode_d;
      acc_q  <= acc_d;
    end
  end

  itc_wr_seq #(.CW(CW), .BW(BW)) u_wr (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .prog     (prog_stb),
    .wr       (wr_stb),
    .acc      (acc_q),
    .wdata    (wdata),
    .load_stb (load_stb),
    .load_val (load_val)
  );

  itc_core #(.CW(CW)) u_core (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .prog      (prog_stb),
    .prog_mode (dec_mode),
    .mode      (mode_q),
    .load_stb  (load_stb),
    .load_val  (load_val),
    .en_tick   (en_tick),
    .cnt       (cnt_q),
    .run       (run_q),
    .out       (tmr_out)
  );

  itc_rd_seq #(.CW(CW), .BW(BW)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .prog     (prog_stb),
    .latch    (latch_stb),
    .rd       (data_re),
    .acc      (acc_q),
    .cnt_live (cnt_q[CW-1:0]),
    .rdata    (rdata),
    .latched  (latched)
  );
endmodule

// File: rtl/itc_chk.sv
module itc_chk import itc_pkg::*; #(
  parameter int CW = 16,
  parameter int BW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          gate,
  input logic          cmd_we,
  input logic          data_re,
  input logic [BW-1:0] wdata,
  input logic [BW-1:0] rdata,
  input logic          tmr_out,
  input mode_e         mode,
  input logic          run,
  input logic          latched,
  input logic          load_stb,
  input logic [CW:0]   cnt
);
  // R2
  cmd_init_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && (wdata[5:4] != 2'b00)) |=> (!run && (tmr_out == $past(wdata[2]))));

  // R4
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick && gate) |=> $stable(cnt));

  // R5
  term_out_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_TERM && tmr_out && !cmd_we && !load_stb) |=> tmr_out);

  // R7
  rate_low_one_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_RATE && run && !tmr_out && tick && gate && !cmd_we) |=> tmr_out);

  // R10
  latch_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (latched && !data_re && !cmd_we) |=> ($stable(rdata) && latched));
endmodule

bind interval_timer_chan itc_chk #(.CW(CW), .BW(BW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n_int),
  .tick     (tick),
  .gate     (gate),
  .cmd_we   (cmd_we),
  .data_re  (data_re),
  .wdata    (wdata),
  .rdata    (rdata),
  .tmr_out  (tmr_out),
  .mode     (mode_q),
  .run      (run_q),
  .latched  (latched),
  .load_stb (load_stb),
  .cnt      (cnt_q)
);

// File: tb/interval_timer_chan_test.sv
module interval_timer_chan_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic       gate = 1'b1;
  logic       cmd_we = 1'b0;
  logic       data_we = 1'b0;
  logic       data_re = 1'b0;
  logic [7:0] wdata = 8'h00;
  wire  [7:0] rdata;
  wire        tmr_out;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  interval_timer_chan #(.CW(16), .BW(8)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .gate(gate), .cmd_we(cmd_we),
    .data_we(data_we), .data_re(data_re), .wdata(wdata), .rdata(rdata),
    .tmr_out(tmr_out)
  );

  function automatic int full(input int n);
    return (n == 0) ? 65536 : n;
  endfunction
  function automatic int exp_term(input int n);
    return full(n) + 1;
  endfunction
  function automatic int exp_rate(input int n);
    return (full(n) < 2) ? 2 : full(n);
  endfunction
  function automatic int exp_sq_hi(input int n);
    return (full(n) + 1) / 2;
  endfunction
  function automatic int exp_sq_lo(input int n);
    return (full(n) / 2 < 1) ? 1 : full(n) / 2;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling clock edge
  task automatic cmd(input logic [7:0] b);
    wdata = b; cmd_we = 1'b1; @(negedge clk); cmd_we = 1'b0;
  endtask
  task automatic wr(input logic [7:0] b);
    wdata = b; data_we = 1'b1; @(negedge clk); data_we = 1'b0;
  endtask
  task automatic wr16(input int v);
    wr(v[7:0]); wr(v[15:8]);
  endtask
  task automatic rd(output logic [7:0] b);
    b = rdata; data_re = 1'b1; @(negedge clk); data_re = 1'b0;
  endtask
  task automatic rd16(output int v);
    logic [7:0] lo, hi;
    rd(lo); rd(hi); v = {16'd0, hi, lo};
  endtask
  task automatic wait_level(input logic lvl, output int k);
    k = 0;
    while (tmr_out !== lvl && k < 70000) begin @(negedge clk); k++; end
  endtask
  task automatic run_term(input string req, input logic [7:0] c, input int n);
    int k;
    cmd(c); wr16(n);
    check({req, " out low after load"}, tmr_out, 0);
    wait_level(1'b1, k);
    check({req, " terminal delay"}, k, exp_term(n));
  endtask
  task automatic run_rate(input string req, input logic [7:0] c, input int n);
    int k0, k1, k2;
    cmd(c); wr16(n);
    wait_level(1'b0, k0); wait_level(1'b1, k1); wait_level(1'b0, k2);
    check({req, " low width"}, k1, 1);
    check({req, " period"}, k1 + k2, exp_rate(n));
  endtask
  task automatic run_sq(input string req, input logic [7:0] c, input int n);
    int k0, k1, k2;
    cmd(c); wr16(n);
    wait_level(1'b0, k0); wait_level(1'b1, k1); wait_level(1'b0, k2);
    check({req, " low phase"}, k1, exp_sq_lo(n));
    check({req, " high phase"}, k2, exp_sq_hi(n));
  endtask

  initial begin
    int k, v;
    logic [7:0] b;
    void'($urandom(32'd7319));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R11 reset state
    check("R11 out at reset", tmr_out, 0);
    check("R11 count at reset", rdata, 0);
    wr16(3); wait_level(1'b1, k);
    check("R11 default access and mode", k, 4);

    // R2 command level and stop
    cmd(8'h30); wr16(40); repeat (5) @(negedge clk);
    cmd(8'h34);
    check("R2 rate initial level", tmr_out, 1);
    rd16(v); repeat (8) @(negedge clk); rd16(k);
    check("R2 count frozen after command", k, v);
    cmd(8'h30);
    check("R2 terminal initial level", tmr_out, 0);

    // R5 terminal mode
    run_term("R5", 8'h30, 1);
    run_term("R5", 8'h30, 2);
    run_term("R5", 8'h30, 300);
    repeat (20) @(negedge clk);
    check("R5 out stays high", tmr_out, 1);

    // R3 access forms
    cmd(8'h10); wr(8'd5); wait_level(1'b1, k);
    check("R3 low-only load", k, 6);
    cmd(8'h20); wr(8'd1); wait_level(1'b1, k);
    check("R3 high-only load", k, 257);
    run_term("R3 low then high", 8'h30, 16'h0102);

    // R1 ignored fields and aliases
    run_term("R1 channel and bcd bits ignored", 8'hF1, 9);
    run_term("R1 code 001 as terminal", 8'h32, 7);
    run_rate("R1 code 110 alias", 8'h3C, 9);
    run_sq("R1 code 111 alias", 8'h3E, 10);

    // R4 gate
    cmd(8'h30); gate = 1'b0; wr16(10);
    repeat (30) @(negedge clk);
    check("R4 no count with gate low", tmr_out, 0);
    gate = 1'b1; wait_level(1'b1, k);
    check("R4 delay after gate", k, 11);

    // R6 rewrite in terminal mode
    run_term("R6 first", 8'h30, 5);
    wr16(20);
    check("R6 out forced low", tmr_out, 0);
    wait_level(1'b1, k);
    check("R6 restart delay", k, 21);

    // R7 rate mode
    run_rate("R7", 8'h34, 1);
    run_rate("R7", 8'h34, 2);
    run_rate("R7", 8'h34, 57);

    // R8 square mode
    run_sq("R8", 8'h36, 1);
    run_sq("R8", 8'h36, 7);
    run_sq("R8", 8'h36, 20);

    // R12 deferred reload
    cmd(8'h14); wr(8'd30);
    wait_level(1'b0, k);
    wr(8'd12);
    wait_level(1'b0, k);
    check("R12 current period kept", k, 29);
    wait_level(1'b1, k); wait_level(1'b0, v);
    check("R12 new period", k + v, 12);

    // R10 latch
    cmd(8'h30); wr16(1000);
    repeat (5) @(negedge clk);
    cmd(8'h00);
    repeat (20) @(negedge clk);
    cmd(8'h00);
    rd(b);
    check("R10 low byte first", b, 8'hE4);
    rd(b);
    check("R10 high byte second", b, 8'h03);
    cmd(8'h00);
    rd16(v);
    check("R10 new latch after release", v, 972);

    // random mix
    for (int i = 0; i < 8; i++) begin
      int code, n;
      code = int'($urandom % 8);
      n = 2 + int'($urandom % 150);
      if (code[1:0] == 2'b10)      run_rate("R7 random", 8'h30 | 8'(code << 1), n);
      else if (code[1:0] == 2'b11) run_sq("R8 random", 8'h30 | 8'(code << 1), n);
      else                         run_term("R5 random", 8'h30 | 8'(code << 1), n);
    end

    // R9 zero count
    run_term("R9 zero as full range", 8'h30, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule